// File: doc/BRIEF.md
# Vector Byte-Granular Right Shifter with Instruction Decode

This block takes one 32-bit instruction word together with two 128-bit operand values and, when the word encodes a whole-register right shift by bytes, returns the shifted vector, the three register numbers named by the word and a match flag. The first operand is the data to shift. The second operand supplies only the byte count. All other bits of the second operand have no effect.

Two encodings of the operation are accepted. The short form carries 5-bit register numbers in three contiguous fields. The wide form carries 7-bit register numbers whose upper bits are scattered across the low part of the word. Inputs are captured on a clock edge while a valid strobe is high. All outputs appear one cycle later, together with a result-valid strobe.

Byte numbering is big-endian. Byte 0 is the most significant byte of the vector and byte 15 is the least significant. A right shift moves bytes toward byte 15 and feeds zero bytes in from byte 0.

Top module: `vec_octet_shr`

## Requirements
- R1: A word matches the short form when word[31:26]=4 and word[10:0]=0x44C, with word[25:11] free. Then rd=word[25:21], ra=word[20:16] and rb=word[15:11], each zero-extended to 7 bits.
- R2: A word matches the wide form when word[31:26]=5, word[9:6]=4'b1111 and word[4]=1, with word[25:10], word[5] and word[3:0] free. Then rd={word[3:2],word[25:21]}, ra={word[10],word[5],word[20:16]} and rb={word[1:0],word[15:11]}.
- R3: A word that differs from both canonical words (0x1000044C and 0x140003D0) in any non-register bit gives hit=0.
- R4: The byte count N is bit-field [6:3] of the second operand, so N ranges from 0 to 15. Operand bits [2:0], bit [7] and bits [127:8] do not change the result.
- R5: The result is the first operand shifted right by 8*N bits, with zeros filling from the top. When N=0 the first operand passes through unchanged.
- R6: The result, hit flag and register numbers update one cycle after a cycle with in_valid high, and out_valid is high exactly in that cycle. While in_valid is low, the outputs hold.
- R7: While rst_n is low at a clock edge, out_valid and all outputs clear to zero.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Capture strobe for the word and operands |
| instr | input | 32 | Instruction word, bit 31 is the word MSB |
| opnd_a | input | 128 | Data to shift |
| opnd_b | input | 128 | Count source, bits [6:3] used |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| hit | output | 1 | Word matched one of the two forms |
| rd_num | output | 7 | Destination register number |
| ra_num | output | 7 | Data source register number |
| rb_num | output | 7 | Count source register number |
| result | output | 128 | Shifted vector |

## Verification
The bench builds the block with its default shape: 16 lanes of 8 bits and the count read from bits 6:3. With that shape every one of the 16 shift counts can be swept, each under junk in the ignored operand bits. Every fixed bit of both canonical words is flipped in turn. The wide form is exercised with all-zero, all-one and mixed 7-bit register numbers, which checks each scattered bit position separately.

// File: rtl/vosr_pkg.sv
// Shared encoding constants and decode record for the byte right shifter.
// Assumes bit 31 of the word is the most significant (first) bit.
package vosr_pkg;
    localparam int REG_W = 7;
    localparam int LO_W  = 5;

    localparam logic [31:0] SHORT_WORD = 32'h1000_044C;
    localparam logic [31:0] WIDE_WORD  = 32'h1400_03D0;
    // Positions that carry register bits in each form.
    localparam logic [31:0] SHORT_REGS = 32'h03FF_F800;
    localparam logic [31:0] WIDE_REGS  = 32'h03FF_FC2F;

    typedef struct packed {
        logic             short_hit;
        logic             wide_hit;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] ra;
        logic [REG_W-1:0] rb;
    } dec_t;
endpackage

// File: rtl/vosr_decode.sv
// Recognises both encodings of the byte right shift and extracts the
// register numbers. Assumes a purely combinational use; results are
// registered by the parent.
module vosr_decode
    import vosr_pkg::*;
(
    input  logic [31:0] word,
    output dec_t        dec
);
    localparam logic [31:0] SHORT_FIX = ~SHORT_REGS;
    localparam logic [31:0] WIDE_FIX  = ~WIDE_REGS;

    // Match on fixed bits and assemble register numbers for the matching form.
    always_comb begin
        dec.short_hit = (word & SHORT_FIX) == (SHORT_WORD & SHORT_FIX);
        dec.wide_hit  = (word & WIDE_FIX)  == (WIDE_WORD  & WIDE_FIX);
        if (dec.wide_hit) begin
            dec.rd = {word[3:2], word[25:21]};
            dec.ra = {word[10], word[5], word[20:16]};
            dec.rb = {word[1:0], word[15:11]};
        end else begin
            dec.rd = {{(REG_W-LO_W){1'b0}}, word[25:21]};
            dec.ra = {{(REG_W-LO_W){1'b0}}, word[20:16]};
            dec.rb = {{(REG_W-LO_W){1'b0}}, word[15:11]};
        end
    end

    // Guard the decode outcome.
    always_comb begin
        AST_ONE_FORM: assert ($onehot0({dec.short_hit, dec.wide_hit})); // R3
        if (dec.short_hit) begin
            AST_SHORT_ZEXT: assert (dec.rd[REG_W-1:LO_W] == '0 && dec.ra[REG_W-1:LO_W] == '0
                                    && dec.rb[REG_W-1:LO_W] == '0); // R1
        end
    end
endmodule

// File: rtl/vosr_shifter.sv
// Whole-vector right shift by a byte count, built as one mux per lane.
// Lane 0 is the least significant byte; zero lanes enter at the top.
module vosr_shifter #(
    parameter int LANES  = 16,
    parameter int BYTE_W = 8,
    localparam int DATA_W = LANES * BYTE_W,
    localparam int CNT_W  = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [CNT_W-1:0]  cnt,
    output logic [DATA_W-1:0] dout
);
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        // Pick the source lane j+cnt, or zero past the top.
        always_comb begin
            if (j + int'(cnt) < LANES)
                dout[j*BYTE_W +: BYTE_W] = din[(j + int'(cnt))*BYTE_W +: BYTE_W];
            else
                dout[j*BYTE_W +: BYTE_W] = '0;
        end
    end

    // Guard pass-through and zero fill.
    always_comb begin
        if (cnt == '0) begin
            AST_ZERO_PASS: assert (dout == din); // R5
        end
        AST_TOP_FILL: assert ((dout >> ((LANES - int'(cnt)) * BYTE_W)) == '0); // R5
    end
endmodule

// File: rtl/vec_octet_shr.sv
// Top: decodes one instruction word, shifts operand A right by the byte
// count in operand B bits [CNT_LSB+CNT_W-1:CNT_LSB], and registers all
// outputs for one cycle. Assumes synchronous active-low reset.
module vec_octet_shr
    import vosr_pkg::*;
#(
    parameter int LANES   = 16,
    parameter int BYTE_W  = 8,
    parameter int CNT_LSB = 3,
    localparam int DATA_W = LANES * BYTE_W,
    localparam int CNT_W  = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       instr,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic              out_valid,
    output logic              hit,
    output logic [REG_W-1:0]  rd_num,
    output logic [REG_W-1:0]  ra_num,
    output logic [REG_W-1:0]  rb_num,
    output logic [DATA_W-1:0] result
);
    dec_t              dec;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] shifted;
    logic              unused_b;

    assign cnt      = opnd_b[CNT_LSB +: CNT_W];
    assign unused_b = ^{opnd_b[DATA_W-1:CNT_LSB+CNT_W], opnd_b[CNT_LSB-1:0]};

    vosr_decode u_dec (
        .word (instr),
        .dec  (dec)
    );

    vosr_shifter #(.LANES(LANES), .BYTE_W(BYTE_W)) u_shf (
        .din  (opnd_a),
        .cnt  (cnt),
        .dout (shifted)
    );

    // Output register: clear on reset, load on in_valid, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            hit       <= 1'b0;
            rd_num    <= '0;
            ra_num    <= '0;
            rb_num    <= '0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                hit    <= dec.short_hit | dec.wide_hit;
                rd_num <= dec.rd;
                ra_num <= dec.ra;
                rb_num <= dec.rb;
                result <= shifted;
            end
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> out_valid == $past(in_valid)); // R6
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> ($stable(result) && $stable(hit))); // R6
    AST_HOLD_REGS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> ($stable(rd_num) && $stable(ra_num) && $stable(rb_num))); // R6
endmodule

// File: tb/sim_vec_octet_shr.sv
module sim_vec_octet_shr;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  instr = '0;
    logic [127:0] opnd_a = '0;
    logic [127:0] opnd_b = '0;
    logic         out_valid, hit;
    logic [6:0]   rd_num, ra_num, rb_num;
    logic [127:0] result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    vec_octet_shr u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid), .hit(hit),
        .rd_num(rd_num), .ra_num(ra_num), .rb_num(rb_num), .result(result)
    );

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] short_w(logic [4:0] d, logic [4:0] a, logic [4:0] b);
        return 32'h1000044C | (32'(d) << 21) | (32'(a) << 16) | (32'(b) << 11);
    endfunction

    function automatic logic [31:0] wide_w(logic [6:0] d, logic [6:0] a, logic [6:0] b);
        return 32'h140003D0 | (32'(d[4:0]) << 21) | (32'(a[4:0]) << 16) | (32'(b[4:0]) << 11)
             | (32'(a[6]) << 10) | (32'(a[5]) << 5) | (32'(d[6:5]) << 2) | 32'(b[6:5]);
    endfunction

    function automatic logic [127:0] pat(int seed);
        logic [127:0] v = '0;
        for (int i = 0; i < 16; i++) v[i*8 +: 8] = 8'(seed * 37 + i * 29 + 1);
        return v;
    endfunction

    // Issue one operation at a falling edge; return one cycle later at the next falling edge.
    task automatic issue(logic [31:0] w, logic [127:0] a, logic [127:0] b);
        @(negedge clk);
        instr = w; opnd_a = a; opnd_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [127:0] a, b, exp, keep;
        repeat (3) @(negedge clk);
        chk("R7 reset valid", 128'(out_valid), 0);
        chk("R7 reset result", result, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 idle valid", 128'(out_valid), 0);

        // R4/R5: all 16 counts, junk in ignored bits
        for (int n = 0; n < 16; n++) begin
            a = pat(n);
            b = pat(n + 100);
            b[6:3] = 4'(n);
            exp = a >> (n * 8);
            issue(short_w(5'(n), 5'(n+1), 5'(n+2)), a, b);
            chk("R6 valid after issue", 128'(out_valid), 1);
            chk("R5 shift result", result, exp);
            chk("R1 hit short", 128'(hit), 1);
            b = '1; b[6:3] = 4'(n);
            issue(short_w(0, 0, 0), a, b);
            chk("R4 ignored bits all ones", result, exp);
            b = '0; b[6:3] = 4'(n);
            issue(short_w(0, 0, 0), a, b);
            chk("R4 ignored bits all zero", result, exp);
        end

        // R1: short register numbers
        issue(short_w(5'd31, 5'd0, 5'd17), pat(3), '0);
        chk("R1 rd", 128'(rd_num), 31);
        chk("R1 ra", 128'(ra_num), 0);
        chk("R1 rb", 128'(rb_num), 17);
        chk("R5 n=0 passthrough", result, pat(3));

        // R2: wide form register numbers
        for (int k = 0; k < 6; k++) begin
            logic [6:0] d, s, t;
            case (k)
                0: begin d = 0;  s = 0;  t = 0;  end
                1: begin d = 127; s = 127; t = 127; end
                2: begin d = 7'h40; s = 7'h40; t = 7'h40; end
                3: begin d = 7'h20; s = 7'h20; t = 7'h20; end
                4: begin d = 7'h15; s = 7'h6A; t = 7'h33; end
                default: begin d = 7'h61; s = 7'h1F; t = 7'h4C; end
            endcase
            b = '0; b[6:3] = 4'(k + 3);
            issue(wide_w(d, s, t), pat(k + 40), b);
            chk("R2 hit wide", 128'(hit), 1);
            chk("R2 rd", 128'(rd_num), 128'(d));
            chk("R2 ra", 128'(ra_num), 128'(s));
            chk("R2 rb", 128'(rb_num), 128'(t));
            chk("R5 wide result", result, pat(k + 40) >> ((k + 3) * 8));
        end

        // R3: flip each fixed bit of both canonical words
        for (int i = 0; i < 32; i++) begin
            if (i < 11 || i > 25) begin
                issue(32'h1000044C ^ (32'd1 << i), pat(i), '0);
                chk("R3 short fixed bit flipped", 128'(hit), 0);
            end
            if (i > 25 || (i >= 6 && i <= 9) || i == 4) begin
                issue(32'h140003D0 ^ (32'd1 << i), pat(i), '0);
                chk("R3 wide fixed bit flipped", 128'(hit), 0);
            end
        end

        // R6: outputs hold while in_valid low
        b = '0; b[6:3] = 4'd5;
        issue(wide_w(7'd99, 7'd88, 7'd77), pat(9), b);
        keep = result;
        @(negedge clk);
        instr = 32'h0; opnd_a = '1; opnd_b = '0;
        @(negedge clk);
        @(negedge clk);
        chk("R6 valid low while idle", 128'(out_valid), 0);
        chk("R6 result holds", result, keep);
        chk("R6 rd holds", 128'(rd_num), 99);
        chk("R6 hit holds", 128'(hit), 1);

        // R7: reset mid-stream
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1; instr = short_w(1, 2, 3);
        @(negedge clk);
        chk("R7 reset clears valid", 128'(out_valid), 0);
        chk("R7 reset clears result", result, 0);
        chk("R7 reset clears rd", 128'(rd_num), 0);
        in_valid = 1'b0; rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule